// File: doc/BRIEF.md
# Message-Framed Asynchronous Receiver

This block receives asynchronous serial characters and stores them in a word-wide message buffer. The line is sampled on a 16x sample enable, so one bit lasts sixteen sample ticks. Each character has a start bit, eight data bits sent least significant bit first, no parity and one stop bit. Every received byte is written into one byte lane of a 32-bit buffer word through a byte-enable strobe. The byte address starts at a programmable value and goes up by one for each character.

A message is a burst of characters. The message ends when the line has stayed high for eleven bit periods after the message began. The block then sets a sticky end-of-message flag, which drives the interrupt output only when the interrupt enable is set. Software can read the byte address of the last stored character. A stop bit sampled low sets a sticky framing error flag. The character is still stored.

A single-cycle control write sets the interrupt enable. The same write can also load the start address and clear either status flag.

Top module: `msgrx_top`

## Requirements
- R1: A falling edge seen on a tick starts a candidate start bit. If the line is still low on the eighth tick after that edge, the start bit is accepted. Each data bit is then sampled every sixteen ticks, eight bits LSB first, and the stop bit is sampled sixteen ticks after the last data bit.
- R2: A low pulse that has ended by the eighth tick is rejected. It causes no buffer write and does not start a message.
- R3: Each received character causes exactly one buffer write, lasting one clock cycle, with the byte copied onto all four lanes of `buf_wdata`.
- R4: Byte address A is written to word `buf_waddr` = A[AW-1:2], with `buf_be` one-hot at bit A[1:0]. The address increments by one per character and wraps modulo 2^AW.
- R5: `end_addr` holds the byte address of the last stored character.
- R6: On a control write (`cfg_we`=1), if bit 1 is set, the start address loads from `cfg_wdata[AW+3:4]`. If bit 1 is clear, the start address is left unchanged. Each new message reloads the write address from the start address.
- R7: `eom_flag` sets once the line has been high for eleven consecutive bit periods (176 ticks) after the first accepted start bit of a message. It does not set after nine bit periods. A high line with no message never sets it.
- R8: `eom_flag` stays set until a control write with bit 3 set. `irq` is high exactly when `eom_flag` is set and the interrupt enable is set. The interrupt enable is bit 0 and is written on every control write.
- R9: A stop bit sampled low sets `ferr_flag`. The character is still stored.
- R10: `ferr_flag` stays set until a control write with bit 2 set. A control write with bit 2 clear leaves it set.
- R11: After reset, `eom_flag`, `ferr_flag` and `irq` are 0, `end_addr` is 0, and no buffer write occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, synchronous to clk, idle high |
| tick16 | input | 1 | 16x oversampling enable |
| cfg_we | input | 1 | Control write strobe |
| cfg_wdata | input | AW+4 | Bit 0 int enable, bit 1 load start, bit 2 clear framing, bit 3 clear end-of-message, bits AW+3:4 address |
| buf_we | output | 1 | Buffer write strobe |
| buf_waddr | output | AW-2 | Buffer word address |
| buf_be | output | 4 | Byte-lane enables |
| buf_wdata | output | 32 | Received byte copied onto all lanes |
| end_addr | output | AW | Byte address of the last stored character |
| eom_flag | output | 1 | Sticky end-of-message status |
| ferr_flag | output | 1 | Sticky framing error status |
| irq | output | 1 | Masked end-of-message interrupt |

## Verification
The hardest case to reach is the exact edge of the end-of-message window. The idle run also includes any trailing high data bits and the stop bit, so it is not simply the gap after the last character. The bench therefore ends one directed message with a character whose top bit is zero. This fixes where the high run starts, so the flag can be checked just before and just after the eleventh bit period. Sub-half-bit glitches, a stop bit held low and an address run that wraps from the top of the space are driven directly. Random messages with random gaps between characters, random start addresses and random interrupt enables cover the rest.

// File: rtl/msgrx_pkg.sv
package msgrx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  localparam int WORD_BYTES = 4;
  localparam int LANE_W     = 2;
  localparam int CFG_INTEN  = 0;
  localparam int CFG_LOAD   = 1;
  localparam int CFG_CLRFE  = 2;
  localparam int CFG_CLREOM = 3;
  localparam int CFG_ADDR_LSB = 4;
endpackage

// File: rtl/msgrx_bitrx.sv
module msgrx_bitrx
  import msgrx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd,
  input  logic             tick,
  output logic             start_ok,
  output logic             byte_vld,
  output logic [DBITS-1:0] byte_data,
  output logic             byte_ferr
);
  localparam int CW   = $clog2(OSR);
  localparam int BW   = $clog2(DBITS + 1);
  localparam int HALF = OSR / 2 - 1;

  rx_state_e        state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [BW-1:0]    bit_q, bit_d;
  logic [DBITS-1:0] sh_q, sh_d;
  logic             vld_q, vld_d;
  logic             ferr_q, ferr_d;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    bit_d    = bit_q;
    sh_d     = sh_q;
    ferr_d   = ferr_q;
    vld_d    = 1'b0;
    start_ok = 1'b0;
    if (tick) begin
      case (state_q)
        RX_IDLE: begin
          if (!rxd) begin
            state_d = RX_START;
            cnt_d   = '0;
          end
        end
        RX_START: begin
          if (cnt_q == CW'(HALF)) begin
            cnt_d = '0;
            bit_d = '0;
            if (!rxd) begin
              state_d  = RX_DATA;
              start_ok = 1'b1;
            end else begin
              state_d = RX_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == CW'(OSR - 1)) begin
            cnt_d = '0;
            sh_d  = {rxd, sh_q[DBITS-1:1]};
            if (bit_q == BW'(DBITS - 1)) state_d = RX_STOP;
            else bit_d = bit_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          if (cnt_q == CW'(OSR - 1)) begin
            cnt_d   = '0;
            vld_d   = 1'b1;
            ferr_d  = !rxd;
            state_d = RX_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      vld_q   <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      vld_q   <= vld_d;
      ferr_q  <= ferr_d;
    end
  end

  assign byte_vld  = vld_q;
  assign byte_data = sh_q;
  assign byte_ferr = ferr_q;

  // R3: a character completes as a single-cycle event
  assert_vld_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);
endmodule

// File: rtl/msgrx_idle.sv
module msgrx_idle #(
  parameter int OSR       = 16,
  parameter int IDLE_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  input  logic tick,
  input  logic start_ok,
  output logic msg_start,
  output logic eom_evt
);
  localparam int CW = $clog2(OSR);
  localparam int NW = $clog2(IDLE_BITS + 1);

  logic [CW-1:0] tcnt_q, tcnt_d;
  logic [NW-1:0] nbits_q, nbits_d;
  logic          in_msg_q, in_msg_d;
  logic          evt_q, evt_d;

  assign msg_start = start_ok && !in_msg_q;

  always_comb begin
    tcnt_d   = tcnt_q;
    nbits_d  = nbits_q;
    in_msg_d = in_msg_q;
    evt_d    = 1'b0;
    if (msg_start) in_msg_d = 1'b1;
    if (tick) begin
      if (!rxd) begin
        tcnt_d  = '0;
        nbits_d = '0;
      end else if (nbits_q < NW'(IDLE_BITS)) begin
        if (tcnt_q == CW'(OSR - 1)) begin
          tcnt_d  = '0;
          nbits_d = nbits_q + 1'b1;
          if (nbits_q == NW'(IDLE_BITS - 1) && in_msg_q) begin
            evt_d    = 1'b1;
            in_msg_d = 1'b0;
          end
        end else begin
          tcnt_d = tcnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q   <= '0;
      nbits_q  <= '0;
      in_msg_q <= 1'b0;
      evt_q    <= 1'b0;
    end else begin
      tcnt_q   <= tcnt_d;
      nbits_q  <= nbits_d;
      in_msg_q <= in_msg_d;
      evt_q    <= evt_d;
    end
  end

  assign eom_evt = evt_q;

  // R7: end of message is only ever reported out of a high line
  assert_eom_on_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eom_evt |-> $past(rxd));
endmodule

// File: rtl/msgrx_pack.sv
module msgrx_pack
  import msgrx_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  msg_start,
  input  logic [AW-1:0]         start_addr,
  input  logic                  byte_vld,
  input  logic [7:0]            byte_data,
  output logic                  buf_we,
  output logic [AW-LANE_W-1:0]  buf_waddr,
  output logic [WORD_BYTES-1:0] buf_be,
  output logic [8*WORD_BYTES-1:0] buf_wdata,
  output logic [AW-1:0]         end_addr
);
  logic [AW-1:0] waddr_q, waddr_d;
  logic [AW-1:0] end_q, end_d;

  always_comb begin
    waddr_d = waddr_q;
    end_d   = end_q;
    if (msg_start) begin
      waddr_d = start_addr;
    end else if (byte_vld) begin
      waddr_d = waddr_q + 1'b1;
      end_d   = waddr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waddr_q <= '0;
      end_q   <= '0;
    end else begin
      waddr_q <= waddr_d;
      end_q   <= end_d;
    end
  end

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    assign buf_be[g]          = byte_vld && (waddr_q[LANE_W-1:0] == LANE_W'(g));
    assign buf_wdata[8*g +: 8] = byte_data;
  end

  assign buf_we    = byte_vld;
  assign buf_waddr = waddr_q[AW-1:LANE_W];
  assign end_addr  = end_q;

  // R4: exactly one lane per write
  assert_one_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> ($countones(buf_be) == 1));
  // R5: reported end address names the lane just written
  assert_end_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |=> ((WORD_BYTES'(1) << end_addr[LANE_W-1:0]) == $past(buf_be)));
endmodule

// File: rtl/msgrx_top.sv
module msgrx_top
  import msgrx_pkg::*;
#(
  parameter int AW        = 10,
  parameter int OSR       = 16,
  parameter int IDLE_BITS = 11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rxd,
  input  logic                   tick16,
  input  logic                   cfg_we,
  input  logic [AW+CFG_ADDR_LSB-1:0] cfg_wdata,
  output logic                   buf_we,
  output logic [AW-LANE_W-1:0]   buf_waddr,
  output logic [WORD_BYTES-1:0]  buf_be,
  output logic [8*WORD_BYTES-1:0] buf_wdata,
  output logic [AW-1:0]          end_addr,
  output logic                   eom_flag,
  output logic                   ferr_flag,
  output logic                   irq
);
  logic [1:0]    rsync_q;
  logic          rst_ni;
  logic          start_ok, msg_start, eom_evt;
  logic          byte_vld, byte_ferr;
  logic [7:0]    byte_data;
  logic          inten_q, inten_d;
  logic [AW-1:0] start_q, start_d;
  logic          eom_q, eom_d;
  logic          ferr_q, ferr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  msgrx_bitrx #(.OSR(OSR), .DBITS(8)) u_bitrx (
    .clk(clk), .rst_n(rst_ni), .rxd(rxd), .tick(tick16),
    .start_ok(start_ok), .byte_vld(byte_vld),
    .byte_data(byte_data), .byte_ferr(byte_ferr)
  );

  msgrx_idle #(.OSR(OSR), .IDLE_BITS(IDLE_BITS)) u_idle (
    .clk(clk), .rst_n(rst_ni), .rxd(rxd), .tick(tick16),
    .start_ok(start_ok), .msg_start(msg_start), .eom_evt(eom_evt)
  );

  msgrx_pack #(.AW(AW)) u_pack (
    .clk(clk), .rst_n(rst_ni), .msg_start(msg_start), .start_addr(start_q),
    .byte_vld(byte_vld), .byte_data(byte_data), .buf_we(buf_we),
    .buf_waddr(buf_waddr), .buf_be(buf_be), .buf_wdata(buf_wdata),
    .end_addr(end_addr)
  );

  always_comb begin
    inten_d = inten_q;
    start_d = start_q;
    eom_d   = eom_q;
    ferr_d  = ferr_q;
    if (cfg_we) begin
      inten_d = cfg_wdata[CFG_INTEN];
      if (cfg_wdata[CFG_LOAD])   start_d = cfg_wdata[AW+CFG_ADDR_LSB-1:CFG_ADDR_LSB];
      if (cfg_wdata[CFG_CLREOM]) eom_d   = 1'b0;
      if (cfg_wdata[CFG_CLRFE])  ferr_d  = 1'b0;
    end
    if (eom_evt)                eom_d  = 1'b1;
    if (byte_vld && byte_ferr)  ferr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      inten_q <= 1'b0;
      start_q <= '0;
      eom_q   <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      inten_q <= inten_d;
      start_q <= start_d;
      eom_q   <= eom_d;
      ferr_q  <= ferr_d;
    end
  end

  assign eom_flag  = eom_q;
  assign ferr_flag = ferr_q;
  assign irq       = eom_q && inten_q;

  // R9: a framing error appears only when a character completes
  assert_ferr_on_char_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(ferr_flag) |-> $past(byte_vld));
  // R8: end-of-message status survives cycles without control writes
  assert_eom_sticky_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (eom_flag && !cfg_we) |=> eom_flag);
endmodule

// File: tb/msgrx_top_tb_top.sv
module msgrx_top_tb_top;
  localparam int AW    = 10;
  localparam int AMASK = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic tick16 = 1'b0;
  logic cfg_we = 1'b0;
  logic [AW+3:0] cfg_wdata = '0;
  logic buf_we;
  logic [AW-3:0] buf_waddr;
  logic [3:0] buf_be;
  logic [31:0] buf_wdata;
  logic [AW-1:0] end_addr;
  logic eom_flag, ferr_flag, irq;

  int n_tests = 0;
  int n_fail = 0;
  int wcnt = 0;
  bit done = 0;
  bit cur_inten = 0;
  int exp_start = 0;
  logic [7:0] mem [int];
  logic [7:0] msgb [0:7];

  always #4 clk = ~clk;

  msgrx_top dut_i (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick16(tick16),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .buf_we(buf_we),
    .buf_waddr(buf_waddr), .buf_be(buf_be), .buf_wdata(buf_wdata),
    .end_addr(end_addr), .eom_flag(eom_flag), .ferr_flag(ferr_flag), .irq(irq)
  );

  always @(negedge clk) begin
    if (buf_we) begin
      wcnt++;
      for (int l = 0; l < 4; l++)
        if (buf_be[l]) mem[int'(buf_waddr) * 4 + l] = buf_wdata[8*l +: 8];
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW+3:0] cfgw(bit ie, bit ld, bit cf, bit ce, int a);
    return {AW'(a), ce, cf, ld, ie};
  endfunction

  task automatic cfg_write(bit ie, bit ld, bit cf, bit ce, int a);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = cfgw(ie, ld, cf, ce, a);
    cur_inten = ie;
    if (ld) exp_start = a & AMASK;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic hold(bit v, int nt);
    rxd = v;
    for (int i = 0; i < nt; i++) begin
      @(negedge clk) tick16 = 1'b1;
      @(negedge clk) tick16 = 1'b0;
    end
  endtask

  task automatic send_char(logic [7:0] b, bit stop);
    hold(1'b0, 16);
    for (int i = 0; i < 8; i++) hold(b[i], 16);
    hold(stop, 16);
  endtask

  task automatic check_store(int n, int base);
    int a;
    for (int i = 0; i < n; i++) begin
      a = (base + i) & AMASK;
      chk(mem.exists(a) && mem[a] == msgb[i], "R1/R4 byte at lane address",
          mem.exists(a) ? int'(mem[a]) : -1, int'(msgb[i]));
    end
    chk(end_addr == AW'((base + n - 1) & AMASK), "R5 end address",
        int'(end_addr), (base + n - 1) & AMASK);
  endtask

  task automatic run_msg(int n, bit gaps);
    int w0;
    mem.delete();
    w0 = wcnt;
    for (int i = 0; i < n; i++) begin
      send_char(msgb[i], 1'b1);
      if (gaps) hold(1'b1, 16 * $urandom_range(0, 3));
    end
    hold(1'b1, 16 * 12);
    chk(wcnt - w0 == n, "R3 one write per char", wcnt - w0, n);
    check_store(n, exp_start);
    chk(eom_flag == 1'b1, "R7 end of message", eom_flag, 1);
    chk(irq == cur_inten, "R8 irq masking", irq, cur_inten);
    cfg_write(cur_inten, 0, 0, 1, 0);
    chk(eom_flag == 1'b0 && irq == 1'b0, "R8 clear eom", eom_flag, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int w0;
    void'($urandom(32'h5EED1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk(eom_flag == 0 && ferr_flag == 0 && irq == 0, "R11 flags after reset", {eom_flag, ferr_flag, irq}, 0);
    chk(end_addr == 0, "R11 end address after reset", int'(end_addr), 0);
    chk(wcnt == 0, "R11 no writes after reset", wcnt, 0);

    // R7 idle without a message
    hold(1'b1, 16 * 20);
    chk(eom_flag == 0, "R7 no eom without message", eom_flag, 0);

    // R2 glitch shorter than half a bit
    hold(1'b0, 5);
    hold(1'b1, 16 * 14);
    chk(wcnt == 0, "R2 glitch no write", wcnt, 0);
    chk(eom_flag == 0, "R2 glitch no message", eom_flag, 0);

    // R6 R4 unaligned start, exact eom window R7, masked irq R8
    cfg_write(0, 1, 0, 0, 'h1FE);
    msgb[0] = 8'hA5; msgb[1] = 8'h3C; msgb[2] = 8'h5A;
    mem.delete();
    for (int i = 0; i < 3; i++) send_char(msgb[i], 1'b1);
    hold(1'b1, 16 * 8);
    chk(eom_flag == 0, "R7 no eom after nine idle bits", eom_flag, 0);
    hold(1'b1, 16 * 3);
    chk(eom_flag == 1, "R7 eom after twelve idle bits", eom_flag, 1);
    chk(irq == 0, "R8 irq masked", irq, 0);
    check_store(3, 'h1FE);
    cfg_write(1, 0, 0, 0, 0);
    chk(irq == 1 && eom_flag == 1, "R8 irq when enabled", irq, 1);
    cfg_write(1, 0, 0, 1, 0);
    chk(irq == 0 && eom_flag == 0, "R8 eom cleared", eom_flag, 0);

    // R6 load bit clear keeps start address
    cfg_write(1, 0, 0, 0, 'h055);
    msgb[0] = 8'h11; msgb[1] = 8'hE7;
    run_msg(2, 0);
    chk(mem.exists('h1FE), "R6 reload from unchanged start", mem.exists('h1FE), 1);

    // R9 R10 framing error
    mem.delete();
    w0 = wcnt;
    send_char(8'h81, 1'b0);
    hold(1'b1, 16 * 2);
    send_char(8'h42, 1'b1);
    hold(1'b1, 16 * 12);
    chk(ferr_flag == 1, "R9 framing flag", ferr_flag, 1);
    chk(wcnt - w0 == 2 && mem.exists(exp_start) && mem[exp_start] == 8'h81,
        "R9 bad char stored", wcnt - w0, 2);
    cfg_write(1, 0, 0, 1, 0);
    chk(ferr_flag == 1, "R10 sticky without clear bit", ferr_flag, 1);
    cfg_write(1, 0, 1, 0, 0);
    chk(ferr_flag == 0, "R10 cleared by write one", ferr_flag, 0);

    // R4 wrap at top of address space
    cfg_write(0, 1, 0, 0, AMASK);
    msgb[0] = 8'hC3; msgb[1] = 8'h0F;
    run_msg(2, 0);

    // random messages
    for (int m = 0; m < 12; m++) begin
      int n;
      n = $urandom_range(1, 6);
      cfg_write($urandom_range(0, 1), 1, 0, 0, $urandom_range(0, AMASK));
      for (int i = 0; i < n; i++) msgb[i] = 8'($urandom);
      run_msg(n, 1);
    end
    chk(ferr_flag == 0, "R10 no spurious framing", ferr_flag, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule